// File: doc/BRIEF.md
# Serial Memory Slave Write Engine

This block is the write side of a two-wire serial memory slave. It watches the clock and data lines and recognises START and STOP conditions. A transfer opens with a device byte that carries a 7-bit address and a direction bit. Two word-address bytes follow, high byte first, and then any number of data bytes. The block acknowledges each accepted byte by pulling the data line low during the ninth clock. Data bytes do not go to storage straight away. They collect in a page buffer. A valid flag per location records which offsets hold new data, and the in-page offset wraps around.

A STOP condition that closes a transfer cleanly starts a commit phase. During the commit, the buffered bytes go out through a one-port synchronous write interface to an external memory array, one byte per clock. The `busy_o` output stays high for a fixed, parameterised number of clocks, which models the nonvolatile write time. While busy, the block ignores the bus completely. The array is split into protection blocks using the top bits of the word address. When a block is flagged in `prot_i`, data bytes aimed at it receive no acknowledge and are never written.

Top module: `eeprom_wr_slave`

## Requirements
- R1: The device byte is received MSB first. Bits 7:1 hold the slave address and bit 0 is the direction bit. The byte is acknowledged only when bits 7:1 equal `DEV_ADDR` and bit 0 is 0. Otherwise no acknowledge is given, and every byte is ignored until the next START or STOP.
- R2: Two word-address bytes follow an accepted device byte and both are acknowledged. The target address is the low `ADDR_W` bits of {first byte, second byte}.
- R3: Every data byte aimed at an unprotected block is acknowledged: `sda_oe_o` is high for the ninth clock of that byte. The block changes `sda_oe_o` only while SCL is low.
- R4: Bit k of `prot_i` protects block k, where the block number is the top `BLK_W` bits of the word address. A data byte aimed at a protected block is not acknowledged, and no write to that block ever appears on the memory port.
- R5: Each accepted data byte advances the in-page offset (the low 6 bits of the address) by one, wrapping from 63 to 0. The page bits do not change. For example, 12 bytes starting at offset 60 land at offsets 60..63 and then 0..7, and offset 8 is not touched.
- R6: When more than 64 bytes are sent, later bytes replace earlier ones at the same offset. Each offset is written at most once per commit, and it holds the last byte sent to it.
- R7: A commit starts only on a STOP in the data phase, when at least one data byte was acknowledged and fewer than two bits of a following byte have been clocked in. Memory writes occur only while `busy_o` is high.
- R8: `busy_o` is high for exactly `WR_CYCLES` clocks per commit. While it is high, `sda_oe_o` stays low and START, STOP and data on the bus have no effect.
- R9: A STOP that arrives after two or more bits of a new byte, or any START before the STOP, discards all buffered data without writing anything.
- R10: A transfer that ends with STOP before any data byte is acknowledged causes no write and no busy period.
- R11: After reset, `sda_oe_o`, `busy_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| prot_i | input | 2**BLK_W | Per-block write protection flags |
| sda_oe_o | output | 1 | Pull data line low when high (acknowledge) |
| busy_o | output | 1 | High during the commit period |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The bench targets page wrap from offset 60 and a run of more than 64 bytes. A design that carries into the page bits would write into the next page. A design that commits every received byte instead of the final value per offset would issue too many memory writes. Mid-byte STOP and repeated START are driven to show that nothing aborted reaches memory, while a normal STOP still commits. A START and device byte sent during the busy period must receive no acknowledge, and the busy period is timed against `WR_CYCLES`. Wrong slave addresses, read requests and protected blocks must each withhold the acknowledge and leave memory unchanged.

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6,
  parameter int BLK_W = 2,
  parameter int WR_CYCLES = 200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [(1<<BLK_W)-1:0]   prot_i,
  output logic                    sda_oe_o,
  output logic                    busy_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [7:0]              mem_wdata_o
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA, S_IGN, S_BUSY} st_t;

  st_t              st;
  logic [2:0]       scl_q, sda_q;
  logic [7:0]       shreg, ahi;
  logic [3:0]       bitcnt;
  logic             ack_ph;
  logic [PG_W-1:0]  page;
  logic [PAGE_W-1:0] ofs;
  logic [PAGE-1:0]  vld;
  logic [7:0]       pbuf [PAGE];
  logic [CNT_W-1:0] cnt;
  logic             ack_ok;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_c   = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire in_xfer  = st inside {S_DEV, S_AHI, S_ALO, S_DATA};
  wire byte_done = in_xfer && !start_c && !stop_c && scl_fall && !ack_ph && bitcnt == 4'd8;
  wire data_wr  = byte_done && st == S_DATA && ack_ok;
  wire [ADDR_W-1:0] word_addr = ADDR_W'({ahi, shreg});
  wire blk_prot = prot_i[page[PG_W-1 -: BLK_W]];
  wire [PAGE_W-1:0] cofs = cnt[PAGE_W-1:0];
  wire in_pg = ~|cnt[CNT_W-1:PAGE_W];

  always_comb begin
    case (st)
      S_DEV:   ack_ok = shreg[7:1] == DEV_ADDR && !shreg[0];
      S_DATA:  ack_ok = !blk_prot;
      default: ack_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= '1;
      sda_q    <= '1;
      shreg    <= '0;
      ahi      <= '0;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      page     <= '0;
      ofs      <= '0;
      vld      <= '0;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (st == S_BUSY) begin
        sda_oe_o <= 1'b0;
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(WR_CYCLES - 1)) begin
          st  <= S_IDLE;
          vld <= '0;
        end
      end else if (start_c) begin
        st       <= S_DEV;
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        vld      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        sda_oe_o <= 1'b0;
        if (st == S_DATA && |vld && bitcnt < 4'd2) begin
          st  <= S_BUSY;
          cnt <= '0;
        end else begin
          st  <= S_IDLE;
          vld <= '0;
        end
      end else if (in_xfer) begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_q[1]};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall && ack_ph) begin
          sda_oe_o <= 1'b0;
          ack_ph   <= 1'b0;
          bitcnt   <= '0;
          if (!sda_oe_o) st <= S_IGN;
        end else if (byte_done) begin
          ack_ph   <= 1'b1;
          sda_oe_o <= ack_ok;
          case (st)
            S_DEV: if (ack_ok) st <= S_AHI;
            S_AHI: begin ahi <= shreg; st <= S_ALO; end
            S_ALO: begin
              page <= word_addr[ADDR_W-1:PAGE_W];
              ofs  <= word_addr[PAGE_W-1:0];
              st   <= S_DATA;
            end
            S_DATA: if (ack_ok) begin
              vld[ofs] <= 1'b1;
              ofs      <= ofs + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr) pbuf[ofs] <= shreg;
  end

  assign busy_o      = st == S_BUSY;
  assign mem_we_o    = busy_o && in_pg && vld[cofs];
  assign mem_addr_o  = {page, cofs};
  assign mem_wdata_o = pbuf[cofs];

  assert_sda_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_q[1]);
  assert_no_prot_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !prot_i[mem_addr_o[ADDR_W-1 -: BLK_W]]);
  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W]));
  assert_commit_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_c));
  assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);
endmodule

// File: tb/tb_eeprom_wr_slave.sv
module tb_eeprom_wr_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int WR = 100;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic [3:0] prot = '0;
  logic sda_oe, busy, mem_we;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, errs = 0;
  int exp_mem[int];
  int act_mem[int];
  int wr_count = 0, busy_run = 0;
  bit busy_seen = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wr_slave #(.DEV_ADDR(7'h50), .ADDR_W(13), .PAGE_W(6), .BLK_W(2), .WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .prot_i(prot),
    .sda_oe_o(sda_oe), .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      chk(busy, "R7", "write outside busy", 0, 1);
      act_mem[int'(mem_addr)] = int'(mem_wdata);
      wr_count++;
    end
    if (busy) begin
      busy_seen = 1;
      busy_run++;
      if (sda_oe) chk(0, "R8", "sda driven while busy", 1, 0);
    end else if (busy_run > 0) begin
      chk(busy_run == WR, "R8", "busy length", busy_run, WR);
      busy_run = 0;
    end
  end

  task automatic hwait(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start();
    m_sda = 1; hwait(H); m_scl = 1; hwait(H); m_sda = 0; hwait(H); m_scl = 0; hwait(H);
  endtask
  task automatic bus_stop();
    m_sda = 0; hwait(H); m_scl = 1; hwait(H); m_sda = 1; hwait(H);
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hwait(H); m_scl = 1; hwait(H); m_scl = 0;
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1; hwait(H); m_scl = 1; hwait(H/2); ack = !sda_bus; hwait(H/2); m_scl = 0;
  endtask

  function automatic int mv(input bit actual, input int k);
    if (actual) return act_mem.exists(k) ? act_mem[k] : -1;
    return exp_mem.exists(k) ? exp_mem[k] : -1;
  endfunction

  int base_wr;
  task automatic wr_body(input int addr, input int n, input int seed, input string req);
    bit a; int pg, of; bit pr; logic [7:0] d;
    pg = addr >> 6; of = addr & 63; pr = prot[addr >> 11];
    base_wr = wr_count; busy_seen = 0;
    bus_start();
    send_byte(8'hA0, a); chk(a, "R1", "device ack", int'(a), 1);
    send_byte(8'(addr >> 8), a); chk(a, "R2", "addr hi ack", int'(a), 1);
    send_byte(8'(addr), a); chk(a, "R2", "addr lo ack", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 37);
      send_byte(d, a);
      chk(a == !pr, pr ? "R4" : "R3", "data ack", int'(a), int'(!pr));
      if (!pr) begin exp_mem[pg * 64 + of] = int'(d); of = (of + 1) & 63; end
    end
    bus_stop();
  endtask
  task automatic wr_finish(input int addr, input int n, input string req);
    int bad = 0, pg; bit pr; int nw;
    pg = addr >> 6; pr = prot[addr >> 11];
    nw = pr ? 0 : (n > 64 ? 64 : n);
    hwait(WR + 40);
    chk(busy_seen == (nw > 0), req, "busy seen", int'(busy_seen), int'(nw > 0));
    chk(wr_count - base_wr == nw, req, "memory write count", wr_count - base_wr, nw);
    for (int o = 0; o < 64; o++)
      if (mv(1, pg * 64 + o) != mv(0, pg * 64 + o)) begin
        bad++;
        $display("  page %0d offset %0d: actual=%0d expected=%0d", pg, o, mv(1, pg*64+o), mv(0, pg*64+o));
      end
    chk(bad == 0, req, "page contents mismatches", bad, 0);
  endtask
  task automatic wr_txn(input int addr, input int n, input int seed, input string req);
    wr_body(addr, n, seed, req);
    wr_finish(addr, n, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    hwait(5);
    chk(!sda_oe && !busy && !mem_we, "R11", "outputs in reset", {sda_oe, busy, mem_we}, 0);
    rst_n = 1;
    hwait(5);
    chk(!sda_oe && !busy && !mem_we, "R11", "outputs after reset", {sda_oe, busy, mem_we}, 0);

    wr_txn(13'h0123, 1, 5, "R7");
    wr_txn(5 * 64 + 60, 12, 11, "R5");
    wr_txn(9 * 64 + 10, 70, 3, "R6");

    // R1: wrong address and read request get no acknowledge
    base_wr = wr_count; busy_seen = 0;
    bus_start(); send_byte(8'hA2, a); chk(!a, "R1", "wrong address ack", int'(a), 0);
    send_byte(8'h00, a); chk(!a, "R1", "byte after nack", int'(a), 0);
    bus_stop();
    bus_start(); send_byte(8'hA1, a); chk(!a, "R1", "read bit ack", int'(a), 0);
    bus_stop(); hwait(WR + 40);
    chk(!busy_seen && wr_count == base_wr, "R1", "activity after rejected device", wr_count - base_wr, 0);

    // R4: protected block 2, unprotected block 1
    prot = 4'b0100;
    wr_txn(13'h1005, 3, 40, "R4");
    wr_txn(13'h0800, 2, 60, "R4");
    prot = '0;

    // R9: STOP after 4 bits of a new byte
    base_wr = wr_count; busy_seen = 0;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h02, a); send_byte(8'h40, a);
    send_byte(8'h11, a); chk(a, "R9", "data ack before abort", int'(a), 1);
    send_byte(8'h22, a);
    send_bits(8'hF0, 4);
    bus_stop(); hwait(WR + 40);
    chk(!busy_seen && wr_count == base_wr, "R9", "writes after mid-byte stop", wr_count - base_wr, 0);

    // R9/R10: repeated START drops buffer; new address-only transfer
    base_wr = wr_count; busy_seen = 0;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h03, a); send_byte(8'h00, a);
    send_byte(8'h33, a);
    bus_start(); send_byte(8'hA0, a); chk(a, "R9", "ack after repeated start", int'(a), 1);
    send_byte(8'h03, a); send_byte(8'h10, a);
    bus_stop(); hwait(WR + 40);
    chk(!busy_seen && wr_count == base_wr, "R9", "writes after repeated start", wr_count - base_wr, 0);

    // R10: address only
    base_wr = wr_count; busy_seen = 0;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h04, a); send_byte(8'h00, a);
    bus_stop(); hwait(WR + 40);
    chk(!busy_seen && wr_count == base_wr, "R10", "writes with no data", wr_count - base_wr, 0);

    // R8: bus ignored during busy
    wr_body(13'h0a00, 3, 90, "R8");
    hwait(12);
    chk(busy, "R8", "busy after stop", int'(busy), 1);
    bus_start(); send_byte(8'hA0, a); chk(!a, "R8", "ack during busy", int'(a), 0);
    bus_stop();
    wr_finish(13'h0a00, 3, "R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule